// File: doc/BRIEF.md
# Management Bus Address Target with Strap-Selected Mapping

This block is the device end of a management bus. It receives frames that have already been decoded into a device address, a register address, a direction and write data. It decides whether the frame is addressed to this device. If it is, the block either carries the access straight onto an internal register bus or handles it through a small command/data register pair. The mapping is set by strap inputs that stay static while the block is out of reset.

With the address strap at zero, the block claims every bus address, and each one names the internal device with the same number. With a non-zero strap, the block claims one even address, equal to the strap shifted left by one. At that address it shows only a command register and a data register. A host places a command word, and the block runs the internal access in the background. A busy bit reports the progress and the host polls it. When the half-map strap is set, only the upper strap bit counts. The block then claims the 16 addresses whose top bit matches it, so two devices can share one bus.

Top module: `smi_target`

## Requirements
- R1: With `strap_dual`=0 and `strap_addr`=0, every frame is claimed. It drives one internal access with `ib_dev` equal to `frm_phy` and `ib_reg` equal to `frm_reg`. A read returns `ib_rdata` on `rsp_rdata`, and a write returns 0.
- R2: For a directly mapped frame, `frm_ready` is low from the cycle after acceptance until the edge that samples `ib_ack`. `ib_req` holds until `ib_ack`. `rsp_valid` pulses for one cycle right after that edge.
- R3: With `strap_dual`=1, a frame is claimed only when `frm_phy[4]` equals `strap_addr[3]`. The internal device is `frm_phy[3:0]`, with the top bit cleared. The other strap bits have no effect.
- R4: With `strap_dual`=0 and `strap_addr` non-zero, only `frm_phy` == {`strap_addr`,0} is claimed. Any other address gets no response and starts no internal access.
- R5: At the claimed address, a read of register 0 returns {busy, stored command bits 14:0}. Register 1 reads and writes the data register. Registers 2 to 31 read as 0, and writes to them change nothing.
- R6: An accepted command word starts an access when all three fields hold a valid value: bit 15 is 1, bits 13:12 are 01, and bits 11:10 are 01 (write) or 10 (read). Busy is then set, and `ib_req` is raised with `ib_dev` set to bits 9:5 and `ib_reg` set to bits 4:0.
- R7: An indirect write drives the data register contents on `ib_wdata` with `ib_write`=1.
- R8: An indirect read loads `ib_rdata` into the data register on the same edge that clears busy.
- R9: A command write that arrives while busy is set is answered, but it leaves the stored command and the running access unchanged.
- R10: A command word with any other mode or opcode value, or with bit 15 at 0, is stored with bit 15 cleared and starts no access.
- R11: In command/data mode, a claimed frame is answered on the cycle after acceptance, and `frm_ready` stays high.
- R12: Reset, which is synchronous and active low, clears busy, the command register and the data register. After reset, `frm_ready`=1, `rsp_valid`=0 and `ib_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 4 | Address strap, bus address bits 4:1 |
| strap_dual | input | 1 | Half-map strap |
| frm_valid | input | 1 | Decoded frame present |
| frm_ready | output | 1 | Frame can be accepted |
| frm_phy | input | 5 | Frame device address |
| frm_reg | input | 5 | Frame register address |
| frm_write | input | 1 | 1 = write frame |
| frm_wdata | input | 16 | Frame write data |
| rsp_valid | output | 1 | Response pulse for a claimed frame |
| rsp_rdata | output | 16 | Response read data |
| ib_req | output | 1 | Internal access request |
| ib_write | output | 1 | Internal access direction |
| ib_dev | output | 5 | Internal device select |
| ib_reg | output | 5 | Internal register select |
| ib_wdata | output | 16 | Internal write data |
| ib_ack | input | 1 | Internal access complete |
| ib_rdata | input | 16 | Internal read data, valid with ib_ack |

## Verification
Some rules are checked by assertions on every cycle. A request holds until it is acknowledged, and the frame port stays blocked during a direct access. A miss in command/data mode stays silent. A direct access copies the frame address. An indirect access starts only from a command write, and its target stays frozen while busy. Other behaviour can only be shown by the bench's scenarios. These are the data-register contents after an indirect read or write, and the readback of rejected and no-operation command words. They also include the dual-map offset and the silence of registers 2 to 31, which the bench's reference model compares at every clock.

// File: rtl/smi_tgt_pkg.sv
// Shared widths, mapping modes and command-word field positions for the
// management bus target.
package smi_tgt_pkg;
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        MAP_SINGLE = 2'd0,
        MAP_DUAL   = 2'd1,
        MAP_MULTI  = 2'd2
    } map_mode_e;

    localparam int CMD_BUSY_BIT = 15;
    localparam int CMD_MODE_LO  = 12;
    localparam int CMD_OP_LO    = 10;
    localparam int CMD_DEV_LO   = 5;

    localparam logic [1:0] CMD_MODE_SHORT = 2'b01;
    localparam logic [1:0] CMD_OP_WR      = 2'b01;
    localparam logic [1:0] CMD_OP_RD      = 2'b10;
endpackage

// File: rtl/smi_addr_decode.sv
// Address decoder: picks the mapping mode from the straps and, for the
// frame address given, says whether it is claimed and which internal
// device it names. Assumes the straps are static outside reset.
module smi_addr_decode
    import smi_tgt_pkg::*;
#(
    parameter int PW = PHY_W,
    localparam int SW = PW - 1
) (
    input  logic [SW-1:0] strap,
    input  logic          dual,
    input  logic [PW-1:0] phy,
    output map_mode_e     mode,
    output logic          hit,
    output logic [PW-1:0] dev
);
    // Mode selection from the straps.
    always_comb begin
        if (dual)             mode = MAP_DUAL;
        else if (strap == '0) mode = MAP_SINGLE;
        else                  mode = MAP_MULTI;
    end

    // Claim test and internal device number for each mode.
    always_comb begin
        hit = 1'b0;
        dev = phy;
        case (mode)
            MAP_SINGLE: hit = 1'b1;
            MAP_DUAL: begin
                hit = (phy[PW-1] == strap[SW-1]);
                dev = {1'b0, phy[PW-2:0]};
            end
            default: hit = (phy == {strap, 1'b0});
        endcase
    end
endmodule

// File: rtl/smi_direct_port.sv
// Direct path: holds one claimed frame as an internal bus request until
// the internal bus acknowledges, then issues the response. Assumes the
// top gates new frames while a request is pending.
module smi_direct_port
    import smi_tgt_pkg::*;
#(
    parameter int PW = PHY_W,
    parameter int RW = REG_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [PW-1:0] fr_dev,
    input  logic [RW-1:0] fr_reg,
    input  logic          fr_wr,
    input  logic [DW-1:0] fr_wdata,
    input  logic          ib_ack,
    input  logic [DW-1:0] ib_rdata,
    output logic          pend,
    output logic [PW-1:0] ib_dev,
    output logic [RW-1:0] ib_reg,
    output logic          ib_wr,
    output logic [DW-1:0] ib_wdata,
    output logic          rsp_v,
    output logic [DW-1:0] rsp_d
);
    // Request lifetime and response generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            rsp_v <= 1'b0;
            rsp_d <= '0;
        end else begin
            rsp_v <= 1'b0;
            if (pend && ib_ack) begin
                pend  <= 1'b0;
                rsp_v <= 1'b1;
                rsp_d <= ib_wr ? '0 : ib_rdata;
            end else if (take) begin
                pend <= 1'b1;
            end
        end
    end

    // Capture of the frame fields that the request carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ib_dev   <= '0;
            ib_reg   <= '0;
            ib_wr    <= 1'b0;
            ib_wdata <= '0;
        end else if (take && !pend) begin
            ib_dev   <= fr_dev;
            ib_reg   <= fr_reg;
            ib_wr    <= fr_wr;
            ib_wdata <= fr_wdata;
        end
    end
endmodule

// File: rtl/smi_indirect_regs.sv
// Command/data register pair: answers frames at the device's own address
// and runs one indirect internal access per accepted command, with a busy
// flag for polling. Assumes take is asserted only for claimed frames.
module smi_indirect_regs
    import smi_tgt_pkg::*;
#(
    parameter int PW = PHY_W,
    parameter int RW = REG_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [RW-1:0] fr_reg,
    input  logic          fr_wr,
    input  logic [DW-1:0] fr_wdata,
    input  logic          ib_ack,
    input  logic [DW-1:0] ib_rdata,
    output logic          ib_req,
    output logic [PW-1:0] ib_dev,
    output logic [RW-1:0] ib_reg,
    output logic          ib_wr,
    output logic [DW-1:0] ib_wdata,
    output logic          rsp_v,
    output logic [DW-1:0] rsp_d
);
    logic          busy;
    logic          op_rd;
    logic [DW-2:0] cmd_q;
    logic [DW-1:0] data_q;
    logic          cmd_wr, data_wr, start;

    // Frame-side decode of register writes and of a valid command.
    always_comb begin
        cmd_wr  = take && fr_wr && (fr_reg == RW'(0));
        data_wr = take && fr_wr && (fr_reg == RW'(1));
        start   = fr_wdata[CMD_BUSY_BIT]
               && (fr_wdata[CMD_MODE_LO +: 2] == CMD_MODE_SHORT)
               && ((fr_wdata[CMD_OP_LO +: 2] == CMD_OP_WR)
                || (fr_wdata[CMD_OP_LO +: 2] == CMD_OP_RD));
    end

    // Read response for a claimed frame, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_v <= 1'b0;
            rsp_d <= '0;
        end else begin
            rsp_v <= take;
            if (!take || fr_wr)           rsp_d <= '0;
            else if (fr_reg == RW'(0))    rsp_d <= {busy, cmd_q};
            else if (fr_reg == RW'(1))    rsp_d <= data_q;
            else                          rsp_d <= '0;
        end
    end

    // Command register, busy flag and access direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            op_rd <= 1'b0;
            cmd_q <= '0;
        end else begin
            if (cmd_wr && !busy) begin
                cmd_q <= fr_wdata[DW-2:0];
                if (start) begin
                    busy  <= 1'b1;
                    op_rd <= (fr_wdata[CMD_OP_LO +: 2] == CMD_OP_RD);
                end
            end
            if (busy && ib_ack) busy <= 1'b0;
        end
    end

    // Data register: frame writes, overridden by read completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            if (data_wr) data_q <= fr_wdata;
            if (busy && ib_ack && op_rd) data_q <= ib_rdata;
        end
    end

    assign ib_req   = busy;
    assign ib_dev   = cmd_q[CMD_DEV_LO +: PW];
    assign ib_reg   = cmd_q[RW-1:0];
    assign ib_wr    = !op_rd;
    assign ib_wdata = data_q;
endmodule

// File: rtl/smi_target.sv
// Top of the management bus target: decodes the frame address under the
// strap-selected mode and routes claimed frames to the direct path or to
// the command/data register pair. Assumes straps change only in reset.
module smi_target
    import smi_tgt_pkg::*;
#(
    parameter int PW = PHY_W,
    parameter int RW = REG_W,
    parameter int DW = DATA_W,
    localparam int SW = PW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] strap_addr,
    input  logic          strap_dual,
    input  logic          frm_valid,
    output logic          frm_ready,
    input  logic [PW-1:0] frm_phy,
    input  logic [RW-1:0] frm_reg,
    input  logic          frm_write,
    input  logic [DW-1:0] frm_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          ib_req,
    output logic          ib_write,
    output logic [PW-1:0] ib_dev,
    output logic [RW-1:0] ib_reg,
    output logic [DW-1:0] ib_wdata,
    input  logic          ib_ack,
    input  logic [DW-1:0] ib_rdata
);
    map_mode_e     mode;
    logic          hit, accept, take_dir, take_ind, is_multi;
    logic [PW-1:0] dec_dev;

    logic          d_req, d_wr, d_rv;
    logic [PW-1:0] d_dev;
    logic [RW-1:0] d_reg;
    logic [DW-1:0] d_wd, d_rd;
    logic          i_req, i_wr, i_rv;
    logic [PW-1:0] i_dev;
    logic [RW-1:0] i_reg;
    logic [DW-1:0] i_wd, i_rd;

    smi_addr_decode #(.PW(PW)) u_dec (
        .strap(strap_addr), .dual(strap_dual), .phy(frm_phy),
        .mode(mode), .hit(hit), .dev(dec_dev)
    );

    // Frame acceptance and routing by mode.
    always_comb begin
        is_multi = (mode == MAP_MULTI);
        accept   = frm_valid && frm_ready;
        take_dir = accept && hit && !is_multi;
        take_ind = accept && hit && is_multi;
    end

    smi_direct_port #(.PW(PW), .RW(RW), .DW(DW)) u_dir (
        .clk(clk), .rst_n(rst_n), .take(take_dir),
        .fr_dev(dec_dev), .fr_reg(frm_reg), .fr_wr(frm_write), .fr_wdata(frm_wdata),
        .ib_ack(ib_ack), .ib_rdata(ib_rdata),
        .pend(d_req), .ib_dev(d_dev), .ib_reg(d_reg), .ib_wr(d_wr), .ib_wdata(d_wd),
        .rsp_v(d_rv), .rsp_d(d_rd)
    );

    smi_indirect_regs #(.PW(PW), .RW(RW), .DW(DW)) u_ind (
        .clk(clk), .rst_n(rst_n), .take(take_ind),
        .fr_reg(frm_reg), .fr_wr(frm_write), .fr_wdata(frm_wdata),
        .ib_ack(ib_ack), .ib_rdata(ib_rdata),
        .ib_req(i_req), .ib_dev(i_dev), .ib_reg(i_reg), .ib_wr(i_wr), .ib_wdata(i_wd),
        .rsp_v(i_rv), .rsp_d(i_rd)
    );

    // Output selection: only the path of the current mode is active.
    always_comb begin
        frm_ready = !d_req;
        if (is_multi) begin
            ib_req = i_req; ib_write = i_wr; ib_dev = i_dev; ib_reg = i_reg; ib_wdata = i_wd;
            rsp_valid = i_rv; rsp_rdata = i_rd;
        end else begin
            ib_req = d_req; ib_write = d_wr; ib_dev = d_dev; ib_reg = d_reg; ib_wdata = d_wd;
            rsp_valid = d_rv; rsp_rdata = d_rd;
        end
    end
endmodule

// File: rtl/smi_target_chk.sv
// Protocol checker for smi_target, attached by bind. It relates the frame
// port, the internal bus and the straps over time.
module smi_target_chk #(
    parameter int PW = 5,
    parameter int RW = 5,
    localparam int SW = PW - 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] strap_addr,
    input logic          strap_dual,
    input logic          frm_valid,
    input logic          frm_ready,
    input logic [PW-1:0] frm_phy,
    input logic [RW-1:0] frm_reg,
    input logic          frm_write,
    input logic          rsp_valid,
    input logic          ib_req,
    input logic          ib_ack,
    input logic [PW-1:0] ib_dev,
    input logic [RW-1:0] ib_reg
);
    logic          multi, single;
    logic [PW-1:0] own;
    assign multi  = !strap_dual && (strap_addr != '0);
    assign single = !strap_dual && (strap_addr == '0);
    assign own    = {strap_addr, 1'b0};

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> ib_req);

    // R2
    dir_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi && ib_req) |-> !frm_ready);

    // R1
    single_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single && $rose(ib_req)) |-> (ib_dev == $past(frm_phy) && ib_reg == $past(frm_reg)));

    // R4
    miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (multi && frm_valid && frm_ready && frm_phy != own) |=> !rsp_valid);

    // R6
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (multi && $rose(ib_req)) |->
        $past(frm_valid && frm_write && frm_reg == '0 && frm_phy == own));

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (multi && ib_req && !ib_ack) |=> ($stable(ib_dev) && $stable(ib_reg)));

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ib_req && !rsp_valid && frm_ready));
endmodule

bind smi_target smi_target_chk #(.PW(PW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .strap_dual(strap_dual),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_phy(frm_phy),
    .frm_reg(frm_reg), .frm_write(frm_write), .rsp_valid(rsp_valid),
    .ib_req(ib_req), .ib_ack(ib_ack), .ib_dev(ib_dev), .ib_reg(ib_reg)
);

// File: tb/smi_target_test.sv
module smi_target_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  strap_addr = 0;
    logic        strap_dual = 0;
    logic        frm_valid = 0, frm_write = 0;
    logic [4:0]  frm_phy = 0, frm_reg = 0;
    logic [15:0] frm_wdata = 0;
    logic        frm_ready, rsp_valid, ib_req, ib_write;
    logic [15:0] rsp_rdata, ib_wdata;
    logic [4:0]  ib_dev, ib_reg;
    logic        ib_ack = 0;
    logic [15:0] ib_rdata = 0;

    int checks = 0, fails = 0, lat = 1, cnt = 0;
    string cur = "R12";
    logic [15:0] mem [0:31][0:31];

    always #10 clk = ~clk;

    smi_target uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] seed(input int d, input int r);
        return {1'b1, d[4:0], r[4:0], 5'h15};
    endfunction

    // Internal register bus responder with programmable latency.
    always @(negedge clk) begin
        if (!rst_n) begin ib_ack = 0; cnt = 0; end
        else if (ib_ack) ib_ack = 0;
        else if (ib_req) begin
            if (cnt >= lat) begin
                ib_ack = 1; cnt = 0;
                if (ib_write) mem[ib_dev][ib_reg] = ib_wdata;
                else ib_rdata = mem[ib_dev][ib_reg];
            end else cnt++;
        end
    end

    // Behavioural reference model, advanced on every rising edge.
    bit m_pend, m_wr, m_busy, m_rd, e_rv;
    int m_dev, m_reg;
    logic [15:0] m_wd, m_cmd, m_data, e_rd;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_wr = 0; m_busy = 0; m_rd = 0; e_rv = 0;
            m_cmd = 0; m_data = 0; e_rd = 0; m_dev = 0; m_reg = 0; m_wd = 0;
        end else begin
            bit acc, hit, multi, ob;
            int dev;
            logic [15:0] od, nd;
            bit nv;
            acc = frm_valid && !m_pend;
            multi = !strap_dual && strap_addr != 0;
            if (strap_dual) begin hit = frm_phy[4] == strap_addr[3]; dev = frm_phy[3:0]; end
            else if (!multi) begin hit = 1; dev = frm_phy; end
            else begin hit = frm_phy == {strap_addr, 1'b0}; dev = frm_phy; end
            ob = m_busy; od = m_data; nv = 0; nd = 0;
            if (m_pend && ib_ack) begin nv = 1; nd = m_wr ? 16'h0 : ib_rdata; m_pend = 0; end
            else if (acc && hit && !multi) begin
                m_pend = 1; m_wr = frm_write; m_dev = dev; m_reg = frm_reg; m_wd = frm_wdata;
            end
            if (acc && hit && multi) begin
                nv = 1;
                if (!frm_write) nd = frm_reg == 0 ? {ob, m_cmd[14:0]} : frm_reg == 1 ? od : 16'h0;
                if (frm_write && frm_reg == 1) m_data = frm_wdata;
                if (frm_write && frm_reg == 0 && !ob) begin
                    m_cmd = {1'b0, frm_wdata[14:0]};
                    if (frm_wdata[15] && frm_wdata[13:12] == 2'b01 &&
                        (frm_wdata[11:10] == 2'b01 || frm_wdata[11:10] == 2'b10)) begin
                        m_busy = 1; m_rd = frm_wdata[11:10] == 2'b10;
                    end
                end
            end
            if (ob && ib_ack) begin m_busy = 0; if (m_rd) m_data = ib_rdata; end
            e_rv = nv; e_rd = nd;
        end
    end

    // Per-clock comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit multi, xr, xw;
            int xd, xg;
            logic [15:0] xwd;
            multi = !strap_dual && strap_addr != 0;
            xr = multi ? m_busy : m_pend;
            xw = multi ? !m_rd : m_wr;
            xd = multi ? m_cmd[9:5] : m_dev;
            xg = multi ? m_cmd[4:0] : m_reg;
            xwd = multi ? m_data : m_wd;
            chk(frm_ready == !m_pend, "R2 frm_ready", 16'(frm_ready), 16'(!m_pend));
            chk(rsp_valid == e_rv, {cur, " rsp_valid"}, 16'(rsp_valid), 16'(e_rv));
            if (e_rv) chk(rsp_rdata == e_rd, {cur, " rsp_rdata"}, rsp_rdata, e_rd);
            chk(ib_req == xr, {cur, " ib_req"}, 16'(ib_req), 16'(xr));
            if (xr) begin
                chk(ib_dev == xd[4:0] && ib_reg == xg[4:0] && ib_write == xw,
                    {cur, " ib target"}, {ib_write, ib_dev, ib_reg}, {xw, xd[4:0], xg[4:0]});
                if (xw) chk(ib_wdata == xwd, {cur, " ib_wdata"}, ib_wdata, xwd);
            end
        end
    end

    task automatic send(input logic [4:0] p, input logic [4:0] r, input bit w, input logic [15:0] d);
        @(negedge clk);
        while (!frm_ready) @(negedge clk);
        frm_valid = 1; frm_phy = p; frm_reg = r; frm_write = w; frm_wdata = d;
        @(negedge clk);
        frm_valid = 0;
    endtask

    task automatic xfer(input logic [4:0] p, input logic [4:0] r, input bit w, input logic [15:0] d,
                        output bit got, output logic [15:0] rd);
        int n = 0;
        send(p, r, w, d);
        got = 0; rd = 0;
        while (!got && n < 12) begin
            if (rsp_valid) begin got = 1; rd = rsp_rdata; end
            else begin @(negedge clk); n++; end
        end
    endtask

    task automatic do_reset(input logic [3:0] s, input bit dl);
        @(negedge clk); rst_n = 0; strap_addr = s; strap_dual = dl;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic poll_idle(input logic [4:0] own, output logic [15:0] rd);
        bit got;
        int n = 0;
        rd = 16'h8000;
        while (rd[15] && n < 30) begin xfer(own, 0, 0, 0, got, rd); n++; end
        chk(!rd[15], "R6 busy clears", rd, {1'b0, rd[14:0]});
    endtask

    initial begin
        bit got;
        logic [15:0] rd;
        for (int d = 0; d < 32; d++) for (int r = 0; r < 32; r++) mem[d][r] = seed(d, r);

        // Single-address mapping
        do_reset(4'd0, 1'b0);
        @(negedge clk);
        chk(frm_ready && !rsp_valid && !ib_req, "R12 reset outputs",
            {frm_ready, rsp_valid, ib_req}, 16'h4);
        cur = "R1"; lat = 1;
        xfer(0, 0, 0, 0, got, rd);   chk(got && rd == seed(0, 0), "R1 read phy0", rd, seed(0, 0));
        xfer(17, 9, 0, 0, got, rd);  chk(got && rd == seed(17, 9), "R1 read phy17", rd, seed(17, 9));
        xfer(31, 31, 0, 0, got, rd); chk(got && rd == seed(31, 31), "R1 read phy31", rd, seed(31, 31));
        cur = "R2"; lat = 3;
        send(5, 3, 1, 16'hBEEF);
        chk(!frm_ready, "R2 ready low during access", 16'(frm_ready), 16'h0);
        xfer(5, 3, 0, 0, got, rd);   chk(got && rd == 16'hBEEF, "R2 write then read", rd, 16'hBEEF);

        // Half-map mode, upper strap bit set, lower bits ignored
        do_reset(4'b1010, 1'b1);
        cur = "R3"; lat = 1;
        xfer(20, 2, 0, 0, got, rd);  chk(got && rd == seed(4, 2), "R3 upper half offset", rd, seed(4, 2));
        xfer(3, 1, 0, 0, got, rd);   chk(!got, "R3 lower half silent", 16'(got), 16'h0);
        do_reset(4'b0000, 1'b1);
        xfer(3, 1, 0, 0, got, rd);   chk(got && rd == seed(3, 1), "R3 lower half claimed", rd, seed(3, 1));
        xfer(19, 1, 0, 0, got, rd);  chk(!got, "R3 upper half silent", 16'(got), 16'h0);

        // Command/data mode at address 6
        do_reset(4'b0011, 1'b0);
        cur = "R12";
        xfer(6, 0, 0, 0, got, rd);   chk(got && rd == 0, "R12 command reg reset", rd, 16'h0);
        xfer(6, 1, 0, 0, got, rd);   chk(got && rd == 0, "R12 data reg reset", rd, 16'h0);
        cur = "R4";
        xfer(7, 0, 0, 0, got, rd);   chk(!got, "R4 odd neighbour silent", 16'(got), 16'h0);
        xfer(0, 1, 0, 0, got, rd);   chk(!got, "R4 address 0 silent", 16'(got), 16'h0);
        cur = "R11";
        send(6, 1, 0, 0);
        chk(rsp_valid && frm_ready, "R11 next-cycle response", {rsp_valid, frm_ready}, 16'h3);
        cur = "R7"; lat = 3;
        xfer(6, 1, 1, 16'h1234, got, rd);
        xfer(6, 0, 1, 16'h9400 | (9 << 5) | 4, got, rd);
        xfer(6, 0, 0, 0, got, rd);   chk(rd[15], "R6 busy seen on poll", rd, rd | 16'h8000);
        poll_idle(6, rd);
        chk(mem[9][4] == 16'h1234, "R7 indirect write landed", mem[9][4], 16'h1234);
        cur = "R8";
        xfer(6, 0, 1, 16'h9800 | (2 << 5) | 7, got, rd);
        poll_idle(6, rd);
        xfer(6, 1, 0, 0, got, rd);   chk(rd == seed(2, 7), "R8 read data latched", rd, seed(2, 7));
        cur = "R9";
        xfer(6, 0, 1, 16'h9800 | (1 << 5) | 1, got, rd);
        xfer(6, 0, 1, 16'h9400 | (30 << 5) | 30, got, rd);
        chk(got, "R9 busy write answered", 16'(got), 16'h1);
        poll_idle(6, rd);
        chk(rd == 16'h1821, "R9 command unchanged", rd, 16'h1821);
        chk(mem[30][30] == seed(30, 30), "R9 no stray write", mem[30][30], seed(30, 30));
        cur = "R10";
        xfer(6, 0, 1, 16'h8463, got, rd);
        xfer(6, 0, 0, 0, got, rd);   chk(rd == 16'h0463, "R10 bad mode stored idle", rd, 16'h0463);
        xfer(6, 0, 1, 16'h9C63, got, rd);
        xfer(6, 0, 0, 0, got, rd);   chk(rd == 16'h1C63, "R10 bad opcode stored idle", rd, 16'h1C63);
        xfer(6, 0, 1, 16'h1463, got, rd);
        xfer(6, 0, 0, 0, got, rd);   chk(rd == 16'h1463, "R10 start bit clear idle", rd, 16'h1463);
        cur = "R5";
        xfer(6, 1, 1, 16'h5A5A, got, rd);
        xfer(6, 5, 1, 16'hFFFF, got, rd);
        xfer(6, 5, 0, 0, got, rd);   chk(got && rd == 0, "R5 unimplemented reads 0", rd, 16'h0);
        xfer(6, 1, 0, 0, got, rd);   chk(rd == 16'h5A5A, "R5 data reg untouched", rd, 16'h5A5A);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule